// File: doc/BRIEF.md
# Preemptive Interrupt Nesting Arbiter

This block decides, on every clock, whether the processor must leave what it is running and enter a new exception handler. It compares the most urgent pending request against the current execution level and signals a take when the request is strictly more urgent. Thirty-two external lines each carry a 2-bit programmable priority. Three fixed requests sit above all of them: system reset, the non-maskable request and the hard-fault request.

Each take pushes the level that was running onto an internal nesting stack. A handler-return strobe pops that level, so execution resumes at the interrupted level with no software help. Among external lines of equal level, the line that has waited longest wins. Waiting time comes from a per-line age counter that restarts when the line becomes pending. When ages tie, the lower line number wins.

The control is a two-state machine. In `ST_THREAD` the stack is empty and the level is thread level. In `ST_NESTED` at least one handler is active. The transitions are:
- PREEMPT: `ST_THREAD` to `ST_NESTED` on a take.
- NEST: `ST_NESTED` to itself on a take.
- UNWIND: `ST_NESTED` to itself on a return while more than one entry is stacked.
- RESUME: `ST_NESTED` to `ST_THREAD` on a return that pops the last entry.
- BAD_RETURN: `ST_THREAD` to itself on a return.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset, `exec_level` is 7 (thread level), and `take`, `take_num`, `clr_pend` and `ret_err` are all zero.
- R2: Level codes run from most to least urgent. Reset is 0, non-maskable is 1 and hard fault is 2. External priority p (0..3) maps to level 3+p, and thread is 7. Exception numbers are reset 1, non-maskable 2, hard fault 3 and external line n 16+n. When no take occurs, `take_num` is 0.
- R3: A take occurs only when the best candidate level is numerically lower than `exec_level`. The take appears one clock after the inputs are sampled. In that same cycle `exec_level` shows the taken level.
- R4: `take` is high for one cycle per taken exception. `clr_pend` is one-hot on the taken external line in that cycle and zero at all other times, including for fixed requests.
- R5: Among external candidates of equal level, the line pending for the most cycles wins. Ages saturate at 15 cycles. When ages are equal, the lower line number wins.
- R6: A return while nested restores the level that was running before the matching take, one clock after the strobe. The last return restores level 7.
- R7: A return while at thread level leaves `exec_level` at 7 and raises `ret_err` for one cycle.
- R8: In a cycle with the return strobe high, no take is made. Requests are judged against the restored level from the next cycle on.
- R9: Nesting depth never exceeds 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_pend | input | 32 | Enabled-and-pending external lines |
| line_prio | input | 64 | 2-bit priority per line; line n uses bits 2n+1:2n |
| sys_reset_req | input | 1 | Fixed reset exception request |
| nmi_req | input | 1 | Fixed non-maskable request |
| fault_req | input | 1 | Fixed hard-fault request |
| hdl_return | input | 1 | Handler-return strobe |
| take | output | 1 | One-cycle take-exception strobe |
| take_num | output | 6 | Exception number of the taken request |
| clr_pend | output | 32 | One-hot pending clear for the taken line |
| exec_level | output | 3 | Current execution level code |
| ret_err | output | 1 | Return with an empty stack |

## Verification
A corrupted stack entry does not show when it is written. It shows only on the return that pops it, where `exec_level` takes a wrong value one cycle after `hdl_return`. The next request then wrongly preempts, or is wrongly held off. A stale age counter shows only when two lines of equal level compete, as the wrong `take_num` in the first cycle both are eligible. The bench therefore holds equal-level lines blocked behind a running handler before releasing them. A state register that disagrees with the stack depth shows as a missing or spurious `ret_err` on the next return.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int PRIO_W     = 2;
    localparam int N_FIXED    = 3;
    localparam int N_LEVELS   = N_FIXED + (1 << PRIO_W) + 1;
    localparam int LVL_W      = $clog2(N_LEVELS);
    localparam int EXT_BASE   = 16;

    typedef logic [LVL_W-1:0] level_t;

    localparam level_t LVL_RESET  = level_t'(0);
    localparam level_t LVL_NMI    = level_t'(1);
    localparam level_t LVL_FAULT  = level_t'(2);
    localparam level_t LVL_THREAD = level_t'(N_LEVELS - 1);

    localparam int EXC_RESET = 1;
    localparam int EXC_NMI   = 2;
    localparam int EXC_FAULT = 3;

    typedef enum logic [0:0] {
        ST_THREAD = 1'b0,
        ST_NESTED = 1'b1
    } nest_state_t;

    function automatic level_t prog_level(input logic [PRIO_W-1:0] p);
        return level_t'(N_FIXED) + level_t'(p);
    endfunction
endpackage

// File: rtl/irq_age_track.sv
module irq_age_track #(
    parameter int N_LINES = 32,
    parameter int AGE_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LINES-1:0]       pend,
    output logic [N_LINES*AGE_W-1:0] ages
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [AGE_W-1:0] age_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                age_q <= '0;
            else if (!pend[g])
                age_q <= '0;
            else if (age_q != AGE_MAX)
                age_q <= age_q + 1'b1;
        end
        assign ages[g*AGE_W +: AGE_W] = age_q;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_nest_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int AGE_W   = 4,
    parameter int IDX_W   = 5
) (
    input  logic [N_LINES-1:0]        pend,
    input  logic [N_LINES*PRIO_W-1:0] prio,
    input  logic [N_LINES*AGE_W-1:0]  ages,
    output logic                      found,
    output logic [IDX_W-1:0]          idx,
    output level_t                    lvl
);
    logic [AGE_W-1:0] best_age;
    level_t           this_lvl;
    logic [AGE_W-1:0] this_age;

    always_comb begin
        found    = 1'b0;
        idx      = '0;
        lvl      = LVL_THREAD;
        best_age = '0;
        this_lvl = LVL_THREAD;
        this_age = '0;
        for (int i = 0; i < N_LINES; i++) begin
            this_lvl = prog_level(prio[i*PRIO_W +: PRIO_W]);
            this_age = ages[i*AGE_W +: AGE_W];
            if (pend[i] && (!found || (this_lvl < lvl) ||
                            ((this_lvl == lvl) && (this_age > best_age)))) begin
                found    = 1'b1;
                idx      = IDX_W'(i);
                lvl      = this_lvl;
                best_age = this_age;
            end
        end
    end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  level_t           push_val,
    output level_t           top,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    level_t mem [DEPTH];
    logic [PTR_W-1:0] top_ptr;

    assign top_ptr = PTR_W'(count - 1'b1);
    assign top     = (count == '0) ? LVL_THREAD : mem[top_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push && (count != CNT_W'(DEPTH))) begin
            count <= count + 1'b1;
        end else if (pop && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && (count != CNT_W'(DEPTH)))
            mem[PTR_W'(count)] <= push_val;
    end
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
    import irq_nest_pkg::*;
#(
    parameter int N_LINES     = 32,
    parameter int AGE_W       = 4,
    parameter int STACK_DEPTH = 8
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [N_LINES-1:0]                           line_pend,
    input  logic [N_LINES*irq_nest_pkg::PRIO_W-1:0]      line_prio,
    input  logic                                         sys_reset_req,
    input  logic                                         nmi_req,
    input  logic                                         fault_req,
    input  logic                                         hdl_return,
    output logic                                         take,
    output logic [$clog2(irq_nest_pkg::EXT_BASE+N_LINES)-1:0] take_num,
    output logic [N_LINES-1:0]                           clr_pend,
    output logic [irq_nest_pkg::LVL_W-1:0]               exec_level,
    output logic                                         ret_err
);
    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;
    localparam int NUM_W = $clog2(EXT_BASE + N_LINES);
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    logic [N_LINES*AGE_W-1:0] ages;
    logic                     pick_found;
    logic [IDX_W-1:0]         pick_idx;
    level_t                   pick_lvl;

    logic                     cand_valid;
    level_t                   cand_lvl;
    logic [NUM_W-1:0]         cand_num;
    logic [N_LINES-1:0]       cand_clr;

    level_t                   stk_top;
    logic [CNT_W-1:0]         stk_count;
    logic                     stk_room;
    logic                     preempt;

    nest_state_t              state, state_nx;
    logic                     do_take, do_pop, do_err;

    irq_age_track #(.N_LINES(N_LINES), .AGE_W(AGE_W)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (line_pend),
        .ages  (ages)
    );

    irq_pick #(.N_LINES(N_LINES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
        .pend  (line_pend),
        .prio  (line_prio),
        .ages  (ages),
        .found (pick_found),
        .idx   (pick_idx),
        .lvl   (pick_lvl)
    );

    irq_nest_stack #(.DEPTH(STACK_DEPTH), .CNT_W(CNT_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_take),
        .pop      (do_pop),
        .push_val (exec_level),
        .top      (stk_top),
        .count    (stk_count)
    );

    // Fixed requests outrank every programmable line, reset first.
    always_comb begin
        cand_valid = 1'b1;
        cand_lvl   = LVL_THREAD;
        cand_num   = '0;
        cand_clr   = '0;
        if (sys_reset_req) begin
            cand_lvl = LVL_RESET;
            cand_num = NUM_W'(EXC_RESET);
        end else if (nmi_req) begin
            cand_lvl = LVL_NMI;
            cand_num = NUM_W'(EXC_NMI);
        end else if (fault_req) begin
            cand_lvl = LVL_FAULT;
            cand_num = NUM_W'(EXC_FAULT);
        end else if (pick_found) begin
            cand_lvl = pick_lvl;
            cand_num = NUM_W'(EXT_BASE) + NUM_W'(pick_idx);
            cand_clr = N_LINES'(1) << pick_idx;
        end else begin
            cand_valid = 1'b0;
        end
    end

    assign stk_room = (stk_count != CNT_W'(STACK_DEPTH));
    assign preempt  = cand_valid && (cand_lvl < exec_level) && stk_room;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_THREAD;
        else
            state <= state_nx;
    end

    // Next state and actions
    always_comb begin
        state_nx = state;
        do_take  = 1'b0;
        do_pop   = 1'b0;
        do_err   = 1'b0;
        unique case (state)
            ST_THREAD: begin
                if (hdl_return) begin
                    do_err = 1'b1;                       // BAD_RETURN
                end else if (preempt) begin
                    do_take  = 1'b1;                     // PREEMPT
                    state_nx = ST_NESTED;
                end
            end
            ST_NESTED: begin
                if (hdl_return) begin
                    do_pop = 1'b1;
                    if (stk_count == CNT_W'(1))
                        state_nx = ST_THREAD;            // RESUME
                end else if (preempt) begin
                    do_take = 1'b1;                      // NEST
                end
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take       <= 1'b0;
            take_num   <= '0;
            clr_pend   <= '0;
            ret_err    <= 1'b0;
            exec_level <= LVL_THREAD;
        end else begin
            take     <= do_take;
            take_num <= do_take ? cand_num : '0;
            clr_pend <= do_take ? cand_clr : '0;
            ret_err  <= do_err;
            if (do_take)
                exec_level <= cand_lvl;
            else if (do_pop)
                exec_level <= stk_top;
        end
    end
endmodule

// File: rtl/irq_nest_checker.sv
module irq_nest_checker
    import irq_nest_pkg::*;
#(
    parameter int N_LINES     = 32,
    parameter int STACK_DEPTH = 8,
    parameter int CNT_W       = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hdl_return,
    input logic               take,
    input logic [N_LINES-1:0] clr_pend,
    input level_t             exec_level,
    input logic               ret_err,
    input logic [CNT_W-1:0]   depth
);
    a_r3_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (exec_level < $past(exec_level)));

    a_r4_clear_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_pend) |-> take);

    a_r4_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_pend));

    a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !$past(hdl_return)) |-> (exec_level == $past(exec_level)));

    a_r7_err_at_thread: assert property (@(posedge clk) disable iff (!rst_n)
        ret_err |-> ((exec_level == LVL_THREAD) && !take));

    a_r8_return_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_return |=> !take);

    a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(STACK_DEPTH));
endmodule

bind irq_nest_arbiter irq_nest_checker #(
    .N_LINES     (N_LINES),
    .STACK_DEPTH (STACK_DEPTH),
    .CNT_W       (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdl_return (hdl_return),
    .take       (take),
    .clr_pend   (clr_pend),
    .exec_level (exec_level),
    .ret_err    (ret_err),
    .depth      (stk_count)
);

// File: tb/sim_irq_nest_arbiter.sv
module sim_irq_nest_arbiter;
    localparam int NL = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] b_pend = '0;
    logic [2*NL-1:0] b_prio = '0;
    logic          b_rst = 1'b0, b_nmi = 1'b0, b_fault = 1'b0, b_ret = 1'b0;

    logic          take;
    logic [5:0]    take_num;
    logic [NL-1:0] clr_pend;
    logic [2:0]    exec_level;
    logic          ret_err;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_exec = 7;
    int m_sp = 0;
    int m_stk [16];
    int m_age [NL];
    bit            e_take;
    int            e_num;
    logic [NL-1:0] e_clr;
    bit            e_err;

    always #5 clk = ~clk;

    irq_nest_arbiter u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_pend     (b_pend),
        .line_prio     (b_prio),
        .sys_reset_req (b_rst),
        .nmi_req       (b_nmi),
        .fault_req     (b_fault),
        .hdl_return    (b_ret),
        .take          (take),
        .take_num      (take_num),
        .clr_pend      (clr_pend),
        .exec_level    (exec_level),
        .ret_err       (ret_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_eval();
        bit c_v = 1'b0;
        int c_lvl = 7, c_num = 0, b_age = 0;
        logic [NL-1:0] c_clr = '0;
        if (b_rst) begin c_v = 1; c_lvl = 0; c_num = 1; end
        else if (b_nmi) begin c_v = 1; c_lvl = 1; c_num = 2; end
        else if (b_fault) begin c_v = 1; c_lvl = 2; c_num = 3; end
        else begin
            for (int i = 0; i < NL; i++) begin
                int l = 3 + int'(b_prio[2*i +: 2]);
                if (b_pend[i] && (!c_v || l < c_lvl || (l == c_lvl && m_age[i] > b_age))) begin
                    c_v = 1; c_lvl = l; c_num = 16 + i; b_age = m_age[i];
                    c_clr = '0; c_clr[i] = 1'b1;
                end
            end
        end
        e_take = 0; e_num = 0; e_clr = '0; e_err = 0;
        if (b_ret) begin
            if (m_sp == 0) e_err = 1;
            else begin m_sp--; m_exec = m_stk[m_sp]; end
        end else if (c_v && c_lvl < m_exec) begin
            e_take = 1; e_num = c_num; e_clr = c_clr;
            m_stk[m_sp] = m_exec; m_sp++; m_exec = c_lvl;
        end
        for (int i = 0; i < NL; i++)
            m_age[i] = b_pend[i] ? ((m_age[i] < 15) ? m_age[i] + 1 : 15) : 0;
    endtask

    // One clock: drive at negedge, compare at the next negedge.
    task automatic step();
        model_eval();
        @(posedge clk);
        @(negedge clk);
        check("R3 take", take, e_take);
        check("R2 take_num", take_num, e_num);
        check("R4 clr_pend", clr_pend, e_clr);
        check("R6 exec_level", exec_level, m_exec);
        check("R7 ret_err", ret_err, e_err);
        b_pend = b_pend & ~e_clr;
        if (e_take && e_num == 1) b_rst = 0;
        if (e_take && e_num == 2) b_nmi = 0;
        if (e_take && e_num == 3) b_fault = 0;
        b_ret = 0;
    endtask

    task automatic set_prio(input int line, input int p);
        b_prio[2*line +: 2] = 2'(p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NL; i++) m_age[i] = 0;
        repeat (3) @(negedge clk);
        check("R1 reset exec_level", exec_level, 7);
        check("R1 reset take", take, 0);
        check("R1 reset clr_pend", clr_pend, 0);
        check("R1 reset ret_err", ret_err, 0);
        rst_n = 1'b1;

        // R7: return at thread level
        b_ret = 1; step();
        check("R7 err on empty return", ret_err, 1);
        check("R7 level stays thread", exec_level, 7);
        step();
        check("R7 err one cycle", ret_err, 0);

        // R3/R4: line 5 at priority 1 -> level 4
        set_prio(5, 1); b_pend[5] = 1; step();
        check("R3 take line5", take, 1);
        check("R2 num line5", take_num, 21);
        check("R4 clear line5", clr_pend, 32'h20);
        check("R3 level 4", exec_level, 4);
        step();
        check("R4 take one cycle", take, 0);

        // R3: equal level does not preempt
        set_prio(7, 1); b_pend[7] = 1; step();
        check("R3 equal level blocked", take, 0);
        b_pend[7] = 0;

        // R5: arrival order at level 5, line 9 before line 3
        set_prio(9, 2); set_prio(3, 2);
        b_pend[9] = 1; step();
        b_pend[3] = 1; step();
        check("R3 lower urgency blocked", take, 0);
        b_ret = 1; step();
        check("R8 no take on return", take, 0);
        check("R6 back to thread", exec_level, 7);
        step();
        check("R5 older line wins", take_num, 25);
        check("R5 level 5", exec_level, 5);

        // R2: fixed levels nest above programmable ones
        b_fault = 1; step();
        check("R2 fault num", take_num, 3);
        check("R2 fault level", exec_level, 2);
        b_nmi = 1; step();
        check("R2 nmi num", take_num, 2);
        b_rst = 1; step();
        check("R2 reset num", take_num, 1);
        check("R2 reset level", exec_level, 0);
        b_ret = 1; step();
        check("R6 unwind to nmi", exec_level, 1);
        b_ret = 1; step();
        check("R6 unwind to fault", exec_level, 2);
        b_ret = 1; step();
        check("R6 unwind to level 5", exec_level, 5);
        b_ret = 1; step();
        check("R6 unwind to thread", exec_level, 7);
        step();
        check("R5 waiting line taken", take_num, 19);
        b_ret = 1; step();

        // R5: saturated ages tie, lower index wins
        set_prio(0, 0); b_pend[0] = 1; step();
        check("R3 level 3", exec_level, 3);
        set_prio(20, 3); set_prio(4, 3);
        b_pend[20] = 1;
        repeat (20) step();
        b_pend[4] = 1;
        repeat (20) step();
        b_ret = 1; step();
        step();
        check("R5 tie lower index", take_num, 20);
        b_ret = 1; step();
        step();
        check("R5 remaining line", take_num, 36);

        // constrained random phase (R9 depth via checker)
        b_prio = {$urandom, $urandom};
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 6 == 0) b_pend[$urandom % NL] = 1'b1;
            b_ret   = ($urandom % 5 == 0);
            if ($urandom % 90 == 0) b_nmi = 1;
            if ($urandom % 70 == 0) b_fault = 1;
            if ($urandom % 400 == 0) b_rst = 1;
            if ($urandom % 300 == 0) b_prio = {$urandom, $urandom};
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule